// File: doc/BRIEF.md
# Write-Followed-by-Read Pipeline Interlock

This block detects memory ordering hazards in an eight-stage in-order pipeline (F1, F2, D1, D2, R1, R2, E, W). In that pipeline a data read is issued in R1 and a data write is committed only at the end of W. Without a guard, a read placed right behind a write would complete before that write does. The unit looks at the instruction in the read-issue stage and compares it with the writes still travelling through R2, E and W. It keeps its own record of those three older slots, loaded from the read-issue stage as instructions move forward.

When a hazard is found, `stall_o` freezes F1 through R1. `bubble_o` tells the pipeline to put an empty slot into R2, so that older writes keep draining toward W. Two kinds of conflict count. The first is an exact address match. The second is a write anywhere inside the same protected peripheral frame as the read. A frame is a block of 2^FRAME_LSB addresses, and a per-frame enable bitmap selects which frames are protected. A global mode input turns the interlock off. This lets the plain-ordering behaviour be compared with the protected behaviour.

Top module: `wfr_interlock`

## Requirements
- R1: Reset (active-low, asynchronous) empties the tracked R2/E/W slots. A write accepted before reset causes no stall for a matching read issued after reset.
- R2: In protected mode (`protect_i`=1), a valid, unkilled read in the read-issue stage stalls while a valid write to the same address sits in R2, E or W. A read directly behind such a write stalls for exactly 3 cycles.
- R3: The stall is released in the cycle after the matching write leaves W. With 1 unrelated slot between write and read the read stalls 2 cycles. With 2 slots between them it stalls 1 cycle. With 3 or more slots between them it does not stall.
- R4: In unprotected mode (`protect_i`=0), `stall_o` and `bubble_o` stay low whatever the addresses are.
- R5: The frame number is `addr[AW-1:FRAME_LSB]`, and bit f of `frame_en_i` protects frame f. If the read's frame is enabled, a pending write to any address in that frame stalls the read, just as an exact match does.
- R6: If the read's frame is not enabled, a pending write to a different address in the same frame causes no stall.
- R7: A read that matches several pending writes stays stalled until the youngest of them has left W.
- R8: An entry with `rs_vld_i`=0 or `rs_kill_i`=1 never stalls. When such an entry carries a write, that write never stalls a later read.
- R9: `bubble_o` equals `stall_o` every cycle. The slots injected during a stall are empty, so a read issued right after a stall ends is not stalled by them.
- R10: An entry without the read flag never stalls, even when its address matches a pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| protect_i | input | 1 | 1 = interlock active, 0 = never stall |
| frame_en_i | input | 2^(AW-FRAME_LSB) | Per-frame protection enable, bit index = frame number |
| rs_vld_i | input | 1 | Read-issue stage holds an instruction |
| rs_kill_i | input | 1 | Read-issue stage entry is flushed |
| rs_rd_i | input | 1 | Entry performs a data read |
| rs_wr_i | input | 1 | Entry performs a data write |
| rs_addr_i | input | AW | Entry data address |
| stall_o | output | 1 | Hold F1 through the read-issue stage |
| bubble_o | output | 1 | Insert an empty slot into R2 |

## Verification
The bench first runs directed pairs of a write followed by a read. The distance between them is 0, 1, 2 and 3 slots. The resulting stall lengths of 3, 2, 1 and 0 cycles show whether each tracked stage is compared and whether the release comes one cycle after the write commits. Further directed cases separate four things: exact matching from frame matching, enabled frames from disabled ones, a single pending write from several, and live entries from killed, invalid or write-only ones. A long run of random entries then follows. The addresses are drawn from a few frames, and the mode toggles periodically. Each cycle of that run is compared against a queue-based model of the three older slots, which catches mismatches in how bubbles and held entries advance.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
  localparam int unsigned OLDER_DEPTH = 3;  // R2, E, W behind the read-issue stage

  typedef enum logic [1:0] {
    SLOT_R2 = 2'd0,
    SLOT_E  = 2'd1,
    SLOT_W  = 2'd2
  } slot_e;

  typedef struct packed {
    logic vld;
    logic wr;
  } slot_ctl_t;
endpackage

// File: rtl/wfr_tag_pipe.sv
module wfr_tag_pipe
  import wfr_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned DEPTH = OLDER_DEPTH
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      hold_i,
  input  logic                      in_vld_i,
  input  logic                      in_wr_i,
  input  logic [AW-1:0]             in_addr_i,
  output logic [DEPTH-1:0]          vld_o,
  output logic [DEPTH-1:0]          wr_o,
  output logic [DEPTH-1:0][AW-1:0]  addr_o
);
  slot_ctl_t [DEPTH-1:0] ctl_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    slot_ctl_t ctl_d;
    logic [AW-1:0] addr_d;
    if (s == 0) begin : g_head
      // a held read-issue stage sends an empty slot forward
      always_comb begin
        ctl_d.vld = in_vld_i & ~hold_i;
        ctl_d.wr  = in_wr_i & ~hold_i;
        addr_d    = in_addr_i;
      end
    end else begin : g_body
      always_comb begin
        ctl_d  = ctl_q[s-1];
        addr_d = addr_q[s-1];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q[s]  <= '0;
        addr_q[s] <= '0;
      end else begin
        ctl_q[s]  <= ctl_d;
        addr_q[s] <= addr_d;
      end
    end

    assign vld_o[s]  = ctl_q[s].vld;
    assign wr_o[s]   = ctl_q[s].vld & ctl_q[s].wr;
    assign addr_o[s] = addr_q[s];
  end

  AST_BUBBLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !vld_o[SLOT_R2]) else $error("bubble slot not empty"); // R9

  AST_SLOTS_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o[0] |=> vld_o[1]) else $error("slot lost while advancing"); // R7
endmodule

// File: rtl/wfr_addr_cmp.sv
module wfr_addr_cmp #(
  parameter int unsigned AW        = 12,
  parameter int unsigned FRAME_LSB = 8
) (
  input  logic [AW-1:0] rd_addr_i,
  input  logic          frame_prot_i,
  input  logic          wr_pend_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          hit_o
);
  logic exact_eq, frame_eq;

  assign exact_eq = (rd_addr_i == wr_addr_i);
  assign frame_eq = (rd_addr_i[AW-1:FRAME_LSB] == wr_addr_i[AW-1:FRAME_LSB]);
  assign hit_o    = wr_pend_i & (exact_eq | (frame_prot_i & frame_eq));
endmodule

// File: rtl/wfr_interlock.sv
module wfr_interlock
  import wfr_pkg::*;
#(
  parameter int unsigned AW        = 12,
  parameter int unsigned FRAME_LSB = 8,
  parameter int unsigned DEPTH     = OLDER_DEPTH,
  localparam int unsigned FW       = AW - FRAME_LSB,
  localparam int unsigned NFRAME   = 1 << FW,
  localparam int unsigned RUN_W    = $clog2(DEPTH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              protect_i,
  input  logic [NFRAME-1:0] frame_en_i,
  input  logic              rs_vld_i,
  input  logic              rs_kill_i,
  input  logic              rs_rd_i,
  input  logic              rs_wr_i,
  input  logic [AW-1:0]     rs_addr_i,
  output logic              stall_o,
  output logic              bubble_o
);
  logic                     rs_live, rd_act, frame_prot;
  logic [DEPTH-1:0]         slot_vld, slot_wr, hit;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [FW-1:0]            rd_frame;

  assign rs_live    = rs_vld_i & ~rs_kill_i;
  assign rd_act     = rs_live & rs_rd_i;
  assign rd_frame   = rs_addr_i[AW-1:FRAME_LSB];
  assign frame_prot = frame_en_i[rd_frame];

  wfr_tag_pipe #(.AW(AW), .DEPTH(DEPTH)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (stall_o),
    .in_vld_i  (rs_live),
    .in_wr_i   (rs_wr_i),
    .in_addr_i (rs_addr_i),
    .vld_o     (slot_vld),
    .wr_o      (slot_wr),
    .addr_o    (slot_addr)
  );

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    wfr_addr_cmp #(.AW(AW), .FRAME_LSB(FRAME_LSB)) u_cmp (
      .rd_addr_i    (rs_addr_i),
      .frame_prot_i (frame_prot),
      .wr_pend_i    (slot_wr[s]),
      .wr_addr_i    (slot_addr[s]),
      .hit_o        (hit[s])
    );
  end

  // any hit keeps the read back, so the youngest pending match governs release
  assign stall_o  = protect_i & rd_act & (|hit);
  assign bubble_o = stall_o;

  // consecutive stall cycles, used only by the bound check
  logic [RUN_W-1:0] stall_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stall_run_q <= '0;
    else if (stall_o) stall_run_q <= stall_run_q + 1'b1;
    else              stall_run_q <= '0;
  end

  AST_STALL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (stall_run_q < RUN_W'(DEPTH))) else $error("stall too long"); // R3

  AST_UNPROT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !protect_i |-> !stall_o) else $error("stall in unprotected mode"); // R4

  AST_DEAD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rs_vld_i || rs_kill_i) |-> !stall_o) else $error("dead entry stalled"); // R8

  AST_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs_rd_i |-> !stall_o) else $error("non-read stalled"); // R10

  AST_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (|(slot_vld & slot_wr))) else $error("stall with no pending write"); // R2
endmodule

// File: tb/wfr_interlock_test.sv
module wfr_interlock_test;
  localparam int AW = 12, FL = 8, D = 3, NF = 1 << (AW - FL);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, protect, kill, vld, rd, wr;
  logic [NF-1:0] frame_en;
  logic [AW-1:0] addr;
  logic          stall, bubble;

  wfr_interlock #(.AW(AW), .FRAME_LSB(FL), .DEPTH(D)) uut (
    .clk_i(clk), .rst_ni(rst_n), .protect_i(protect), .frame_en_i(frame_en),
    .rs_vld_i(vld), .rs_kill_i(kill), .rs_rd_i(rd), .rs_wr_i(wr),
    .rs_addr_i(addr), .stall_o(stall), .bubble_o(bubble)
  );

  int total = 0, bad = 0;
  // model of pending slots, front = youngest (R2)
  bit            q_wr[$];
  logic [AW-1:0] q_addr[$];

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    q_wr.delete(); q_addr.delete();
    for (int i = 0; i < D; i++) begin q_wr.push_back(1'b0); q_addr.push_back('0); end
  endtask

  function automatic bit ref_stall();
    bit h = 0;
    if (!protect || !vld || kill || !rd) return 0;
    for (int i = 0; i < D; i++)
      if (q_wr[i] && (q_addr[i] == addr ||
          (frame_en[addr[AW-1:FL]] && q_addr[i][AW-1:FL] == addr[AW-1:FL]))) h = 1;
    return h;
  endfunction

  // called at negedge with inputs driven
  task automatic cyc(output bit st);
    bit e;
    #5;
    e = ref_stall();
    check(stall == e, "R2 stall", int'(stall), int'(e));
    check(bubble == e, "R9 bubble", int'(bubble), int'(e));
    st = e;
    @(posedge clk);
    void'(q_wr.pop_back()); void'(q_addr.pop_back());
    q_wr.push_front(!e && vld && !kill && wr);
    q_addr.push_front(addr);
    @(negedge clk);
  endtask

  task automatic issue(bit v, bit k, bit r, bit w, logic [AW-1:0] a, output int n);
    bit st;
    vld = v; kill = k; rd = r; wr = w; addr = a; n = 0;
    forever begin
      cyc(st);
      if (!st) break;
      n++;
    end
  endtask

  task automatic nops(int c);
    int n;
    for (int i = 0; i < c; i++) issue(0, 0, 0, 0, '0, n);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL R2 watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    vld = 0; kill = 0; rd = 0; wr = 0; addr = '0; protect = 1;
    frame_en = '0;
    frame_en[3] = 1'b1;
    do_reset();

    // R1: write pending, then reset, then matching read
    issue(1, 0, 0, 1, 12'h040, n);
    do_reset();
    issue(1, 0, 1, 0, 12'h040, n);
    check(n == 0, "R1 post-reset read", n, 0);
    nops(3);

    // R2 / R3: distance sweep
    for (int gap = 0; gap < 5; gap++) begin
      issue(1, 0, 0, 1, 12'h050, n);
      nops(gap);
      issue(1, 0, 1, 0, 12'h050, n);
      check(n == ((gap < 3) ? 3 - gap : 0), (gap == 0) ? "R2 back-to-back" : "R3 gap", n,
            (gap < 3) ? 3 - gap : 0);
      nops(3);
    end

    // R9: read right after a stall ends sees no hazard from bubbles
    issue(1, 0, 0, 1, 12'h060, n);
    issue(1, 0, 1, 0, 12'h060, n);
    issue(1, 0, 1, 0, 12'h060, n);
    check(n == 0, "R9 after stall", n, 0);
    nops(3);

    // R4: unprotected
    protect = 0;
    issue(1, 0, 0, 1, 12'h070, n);
    issue(1, 0, 1, 0, 12'h070, n);
    check(n == 0, "R4 unprotected", n, 0);
    protect = 1;
    nops(3);

    // R5: enabled frame 3, different addresses
    issue(1, 0, 0, 1, 12'h310, n);
    issue(1, 0, 1, 0, 12'h3f0, n);
    check(n == 3, "R5 frame hit", n, 3);
    nops(3);

    // R6: disabled frame 5
    issue(1, 0, 0, 1, 12'h510, n);
    issue(1, 0, 1, 0, 12'h520, n);
    check(n == 0, "R6 frame off", n, 0);
    nops(3);

    // R7: several matching writes
    issue(1, 0, 0, 1, 12'h080, n);
    issue(1, 0, 0, 1, 12'h080, n);
    issue(1, 0, 1, 0, 12'h080, n);
    check(n == 3, "R7 youngest", n, 3);
    nops(3);
    issue(1, 0, 0, 1, 12'h080, n);
    issue(1, 0, 0, 1, 12'h090, n);
    issue(1, 0, 1, 0, 12'h080, n);
    check(n == 2, "R7 older only", n, 2);
    nops(3);

    // R8: killed / invalid
    issue(1, 0, 0, 1, 12'h0a0, n);
    issue(1, 1, 1, 0, 12'h0a0, n);
    check(n == 0, "R8 killed read", n, 0);
    issue(0, 0, 1, 0, 12'h0a0, n);
    check(n == 0, "R8 invalid read", n, 0);
    nops(3);
    issue(1, 1, 0, 1, 12'h0b0, n);
    issue(1, 0, 1, 0, 12'h0b0, n);
    check(n == 0, "R8 killed write", n, 0);
    nops(3);

    // R10: write-only behind write
    issue(1, 0, 0, 1, 12'h0c0, n);
    issue(1, 0, 0, 1, 12'h0c0, n);
    check(n == 0, "R10 write only", n, 0);
    nops(3);

    // random phase, model compared every cycle
    frame_en = NF'($urandom);
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      if (i % 60 == 0) protect = ~protect;
      a = {4'($urandom_range(2, 5)), 8'(($urandom_range(0, 2) == 0) ? 8'h20 : 8'($urandom_range(0, 1)))};
      issue(1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 7) == 0),
            1'($urandom), 1'($urandom), a, n);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule